// File: doc/BRIEF.md
# Extended Data Memory Access Router

This block sits between the external-data access port of an 8-bit microcontroller core and two possible targets. One target is a small on-chip RAM that occupies a window of the 64 KiB data space. The other is the external multiplexed address/data bus. A control register in special-function space holds two mapping bits. From these bits and the address of each access, the block decides where every read or write is served. It also decides whether the external strobes and ports mirror on-chip accesses.

Each access is one request cycle. The routing result appears on the registered bus outputs and on the read-return path in the following cycle.

The bit that enables the on-chip RAM is guarded by an unlock interlock. A confirming write can change it only when it directly follows a key write to a dedicated address. This stops a stray single write from remapping the data space.

Top module: `xdata_router`

## Requirements
- R1: After reset the control register (special-function address 0xB1) reads 0x01: bit 0 (on-chip RAM off) is 1 and bit 1 (echo) is 0. Both bus strobes are high and acc_rvalid is low.
- R2: A write to 0xB1 that is not armed loads bit 1 from data bit 1 and leaves bit 0 unchanged.
- R3: A write of key 0xA5 to special-function address 0xB2 arms the interlock. If the very next special-function write goes to 0xB1, it also loads bit 0 from data bit 0. Any other write in between, a wrong key, or a write to another address disarms it.
- R4: While bit 0 is 1, every access drives its strobe low for exactly the next cycle, with bus_addr equal to the access address. Read data comes from bus_din.
- R5: While bit 0 is 0 and bit 1 is 0, an access inside the window (default 0xFF00 to 0xFFFF) is served by the on-chip RAM. Both strobes stay high. Read data returned the next cycle is the last byte written there on chip.
- R6: While bit 0 is 0 and bit 1 is 1, an access inside the window pulses its strobe. It drives bus_addr, and for writes it drives bus_dout with bus_dout_oe. Read data is still taken from the on-chip RAM, never from bus_din.
- R7: An access outside the window always uses the external bus, whatever the value of bit 1.
- R8: An in-window write made while bit 0 is 1 leaves the on-chip RAM contents unchanged.
- R9: Strobes are active low and never both low together. A strobe is low only in the cycle after a request. bus_dout_oe is high only together with the write strobe. When idle, bus_addr and bus_dout are 0.
- R10: sfr_rdata shows {6'b0, bit1, bit0} when sfr_addr is 0xB1 and 0 for any other address.
- R11: An access in the same cycle as a control-register write is routed by the register value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_wr | input | 1 | Special-function write strobe |
| sfr_addr | input | 8 | Special-function address (write and read) |
| sfr_wdata | input | 8 | Special-function write data |
| sfr_rdata | output | 8 | Control register readback |
| acc_req | input | 1 | One-cycle data access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Data-space address |
| acc_wdata | input | 8 | Write data |
| acc_rvalid | output | 1 | Read data valid (cycle after a read request) |
| acc_rdata | output | 8 | Read data |
| bus_rd_n | output | 1 | External read strobe, active low |
| bus_wr_n | output | 1 | External write strobe, active low |
| bus_addr | output | 16 | External address (high and low port) |
| bus_dout | output | 8 | External write data |
| bus_dout_oe | output | 1 | External data drive enable |
| bus_din | input | 8 | External read data |

## Verification
Two functions can meet in one clock edge: a control-register write that remaps the data space, and a data access whose routing depends on that mapping. The bench provokes this by issuing the special-function write and the access in the same cycle. It does so once with a plain write to the echo bit, and once with the confirming write of an unlock sequence. The result is judged against a reference model that routes from the register value held before the edge. It is also judged by explicit strobe and read-data checks in the following cycle.

// File: rtl/xdr_pkg.sv
package xdr_pkg;

  typedef enum logic [1:0] {
    RT_NONE        = 2'd0,
    RT_EXTERNAL    = 2'd1,
    RT_LOCAL_QUIET = 2'd2,
    RT_LOCAL_ECHO  = 2'd3
  } route_e;

  // Routing decision for one access
  function automatic route_e route_of(input logic req, input logic ram_off,
                                      input logic echo, input logic in_win);
    if (!req)                 return RT_NONE;
    else if (ram_off || !in_win) return RT_EXTERNAL;
    else if (echo)            return RT_LOCAL_ECHO;
    else                      return RT_LOCAL_QUIET;
  endfunction

  function automatic logic route_visible(input route_e r);
    return (r == RT_EXTERNAL) || (r == RT_LOCAL_ECHO);
  endfunction

  function automatic logic route_local(input route_e r);
    return (r == RT_LOCAL_QUIET) || (r == RT_LOCAL_ECHO);
  endfunction

endpackage

// File: rtl/xdr_ctrl_reg.sv
module xdr_ctrl_reg #(
  parameter int         SFR_W       = 8,
  parameter logic [7:0] CTRL_ADDR   = 8'hB1,
  parameter logic [7:0] UNLOCK_ADDR = 8'hB2,
  parameter logic [7:0] UNLOCK_KEY  = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SFR_W-1:0] addr,
  input  logic [SFR_W-1:0] wdata,
  output logic [SFR_W-1:0] rdata,
  output logic             ram_off,
  output logic             echo,
  output logic             armed
);

  logic hit_ctrl, hit_key, key_ok;

  assign hit_ctrl = (addr == SFR_W'(CTRL_ADDR));
  assign hit_key  = (addr == SFR_W'(UNLOCK_ADDR));
  assign key_ok   = hit_key && (wdata == SFR_W'(UNLOCK_KEY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_off <= 1'b1;
      echo    <= 1'b0;
      armed   <= 1'b0;
    end else if (wr) begin
      armed <= key_ok;
      if (hit_ctrl) begin
        echo <= wdata[1];
        if (armed) ram_off <= wdata[0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl) rdata[1:0] = {echo, ram_off};
  end

endmodule

// File: rtl/xdr_window.sv
module xdr_window #(
  parameter int            ADDR_W   = 16,
  parameter int            RAM_AW   = 8,
  parameter logic [15:0]   WIN_BASE = 16'hFF00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [RAM_AW-1:0] idx
);

  localparam int TAG_W = ADDR_W - RAM_AW;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);

  function automatic logic tag_match(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:RAM_AW] == BASE[ADDR_W-1:RAM_AW];
  endfunction

  generate
    if (TAG_W > 0) begin : g_tag
      assign in_win = tag_match(addr);
    end else begin : g_full
      assign in_win = 1'b1;
    end
  endgenerate

  assign idx = addr[RAM_AW-1:0];

endmodule

// File: rtl/xdr_ram.sv
module xdr_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end

endmodule

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          SFR_W       = 8,
  parameter int          RAM_AW      = 8,
  parameter logic [15:0] WIN_BASE    = 16'hFF00,
  parameter logic [7:0]  CTRL_ADDR   = 8'hB1,
  parameter logic [7:0]  UNLOCK_ADDR = 8'hB2,
  parameter logic [7:0]  UNLOCK_KEY  = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [SFR_W-1:0]  sfr_addr,
  input  logic [SFR_W-1:0]  sfr_wdata,
  output logic [SFR_W-1:0]  sfr_rdata,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_rvalid,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_oe,
  input  logic [DATA_W-1:0] bus_din
);
  import xdr_pkg::*;

  // Named internal events, visible to the checker
  logic              map_off, map_echo, armed, in_win;
  logic [RAM_AW-1:0] ram_idx;
  logic [DATA_W-1:0] ram_q;
  route_e            route;
  logic              ev_visible, ev_local, ev_local_wr, ev_local_rd;
  logic              src_local_q;

  xdr_ctrl_reg #(
    .SFR_W(SFR_W), .CTRL_ADDR(CTRL_ADDR),
    .UNLOCK_ADDR(UNLOCK_ADDR), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(sfr_wr), .addr(sfr_addr),
    .wdata(sfr_wdata), .rdata(sfr_rdata),
    .ram_off(map_off), .echo(map_echo), .armed(armed)
  );

  xdr_window #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .WIN_BASE(WIN_BASE)) u_win (
    .addr(acc_addr), .in_win(in_win), .idx(ram_idx)
  );

  assign route       = route_of(acc_req, map_off, map_echo, in_win);
  assign ev_visible  = route_visible(route);
  assign ev_local    = route_local(route);
  assign ev_local_wr = ev_local && acc_we;
  assign ev_local_rd = ev_local && !acc_we;

  xdr_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .we(ev_local_wr), .re(ev_local_rd),
    .addr(ram_idx), .wdata(acc_wdata), .q(ram_q)
  );

  // One-cycle bus phase following the request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rd_n    <= 1'b1;
      bus_wr_n    <= 1'b1;
      bus_addr    <= '0;
      bus_dout    <= '0;
      bus_dout_oe <= 1'b0;
      acc_rvalid  <= 1'b0;
      src_local_q <= 1'b0;
    end else begin
      bus_rd_n    <= !(ev_visible && !acc_we);
      bus_wr_n    <= !(ev_visible && acc_we);
      bus_addr    <= ev_visible ? acc_addr : '0;
      bus_dout    <= (ev_visible && acc_we) ? acc_wdata : '0;
      bus_dout_oe <= ev_visible && acc_we;
      acc_rvalid  <= acc_req && !acc_we;
      src_local_q <= ev_local_rd;
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_rvalid) acc_rdata = src_local_q ? ram_q : bus_din;
  end

endmodule

// File: rtl/xdr_checker.sv
module xdr_checker #(
  parameter logic [7:0] CTRL_ADDR = 8'hB1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sfr_wr,
  input logic [7:0] sfr_addr,
  input logic       acc_req,
  input logic       acc_we,
  input logic       map_off,
  input logic       map_echo,
  input logic       armed,
  input logic       in_win,
  input logic       bus_rd_n,
  input logic       bus_wr_n,
  input logic       bus_dout_oe,
  input logic       acc_rvalid
);

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  a_r9_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_oe |-> !bus_wr_n);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> (bus_rd_n && bus_wr_n));

  a_r4_off_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && map_off) |=> (bus_rd_n != bus_wr_n));

  a_r5_quiet_local: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !map_off && in_win && !map_echo) |=> (bus_rd_n && bus_wr_n));

  a_r6_echo_local: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !map_off && in_win && map_echo) |=> (bus_rd_n != bus_wr_n));

  a_r7_outside_out: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !in_win) |=> (bus_rd_n != bus_wr_n));

  a_r2_bit0_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == CTRL_ADDR && !armed) |=> $stable(map_off));

  a_r4_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_we) |=> acc_rvalid);

endmodule

bind xdata_router xdr_checker #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
  .acc_req(acc_req), .acc_we(acc_we), .map_off(map_off),
  .map_echo(map_echo), .armed(armed), .in_win(in_win),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout_oe(bus_dout_oe),
  .acc_rvalid(acc_rvalid)
);

// File: tb/sim_xdata_router.sv
`timescale 1ns/1ps
module sim_xdata_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00, sfr_rdata;
  logic        acc_req = 1'b0, acc_we = 1'b0;
  logic [15:0] acc_addr = 16'h0;
  logic [7:0]  acc_wdata = 8'h0;
  logic        acc_rvalid;
  logic [7:0]  acc_rdata;
  logic        bus_rd_n, bus_wr_n, bus_dout_oe;
  logic [15:0] bus_addr;
  logic [7:0]  bus_dout;
  logic [7:0]  bus_din = 8'h00;

  always #4 clk = ~clk;

  xdata_router u0 (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .acc_req(acc_req),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_dout_oe(bus_dout_oe), .bus_din(bus_din)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_off = 1, m_echo = 0, m_armed = 0;
  logic [7:0] mem [int];
  int e_rd_n = 1, e_wr_n = 1, e_addr = 0, e_dout = 0, e_oe = 0;
  int e_rv = 0, e_local = 0, e_ram = 0;
  string e_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_off = 1; m_echo = 0; m_armed = 0;
      e_rd_n = 1; e_wr_n = 1; e_addr = 0; e_dout = 0; e_oe = 0;
      e_rv = 0; e_local = 0; e_ram = 0; e_tag = "R1";
    end else begin
      int a, inwin, local_hit, shown;
      a = acc_addr;
      e_rd_n = 1; e_wr_n = 1; e_addr = 0; e_dout = 0; e_oe = 0;
      e_rv = 0; e_local = 0; e_tag = "R9";
      if (acc_req) begin
        inwin     = (a >= 'hFF00) && (a <= 'hFFFF);
        local_hit = (m_off == 0) && inwin;
        shown     = !local_hit || m_echo;
        if (m_off) e_tag = "R4";
        else if (!inwin) e_tag = "R7";
        else if (m_echo) e_tag = "R6";
        else e_tag = "R5";
        if (shown) begin
          e_addr = a;
          if (acc_we) begin e_wr_n = 0; e_dout = acc_wdata; e_oe = 1; end
          else e_rd_n = 0;
        end
        if (!acc_we) begin
          e_rv = 1;
          e_local = local_hit;
          e_ram = (local_hit && mem.exists(a)) ? int'(mem[a]) : 0;
        end
        if (local_hit && acc_we) mem[a] = acc_wdata;
      end
      // control register uses pre-edge state for routing above (R11)
      if (sfr_wr) begin
        if (sfr_addr == 8'hB1) begin
          m_echo = sfr_wdata[1];
          if (m_armed) m_off = sfr_wdata[0];
        end
        m_armed = (sfr_addr == 8'hB2) && (sfr_wdata == 8'hA5);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({e_tag, " rd_n"}, bus_rd_n, e_rd_n);
      chk({e_tag, " wr_n"}, bus_wr_n, e_wr_n);
      chk({e_tag, " addr"}, bus_addr, e_addr);
      chk({e_tag, " dout"}, bus_dout, e_dout);
      chk({e_tag, " oe"}, bus_dout_oe, e_oe);
      chk({e_tag, " rvalid"}, acc_rvalid, e_rv);
      if (e_rv) chk({e_tag, " rdata"}, acc_rdata, e_local ? e_ram : int'(bus_din));
      chk("R10 sfr readback", sfr_rdata,
          (sfr_addr == 8'hB1) ? ((m_echo << 1) | m_off) : 0);
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] got;
  int str_rd, str_wr;

  task automatic step(input bit dsfr, input logic [7:0] sa, input logic [7:0] sd,
                      input bit dacc, input bit we, input logic [15:0] a,
                      input logic [7:0] wd, input logic [7:0] din);
    @(negedge clk); #1;
    sfr_wr = dsfr; sfr_addr = sa; sfr_wdata = sd;
    acc_req = dacc; acc_we = we; acc_addr = a; acc_wdata = wd; bus_din = din;
    @(negedge clk);
    got = acc_rdata; str_rd = bus_rd_n; str_wr = bus_wr_n;
    #1;
    sfr_wr = 0; acc_req = 0; acc_we = 0; acc_addr = 0; acc_wdata = 0;
  endtask

  task automatic sfr_w(input logic [7:0] sa, input logic [7:0] sd);
    step(1, sa, sd, 0, 0, 16'h0, 8'h0, 8'h0);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    step(0, 8'h00, 8'h00, 1, 1, a, d, 8'h00);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] din);
    step(0, 8'h00, 8'h00, 1, 0, a, 8'h00, din);
  endtask

  task automatic peek(input string tag, input logic [7:0] sa, input int exp);
    @(negedge clk); #1; sfr_addr = sa; #1;
    chk(tag, sfr_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    #1 sfr_addr = 8'hB1; #1;
    chk("R1 reg", sfr_rdata, 8'h01);
    chk("R1 rd_n", bus_rd_n, 1); chk("R1 wr_n", bus_wr_n, 1);
    chk("R1 rvalid", acc_rvalid, 0);
    rst_n = 1;

    // R4: RAM off, everything external
    wr(16'hFF10, 8'h3C); chk("R4 wr strobe", str_wr, 0);
    rd(16'hFF10, 8'h5A); chk("R4 read from bus", got, 8'h5A);
    rd(16'h1234, 8'h77); chk("R4 outside read", got, 8'h77);

    // R2: unarmed writes touch only bit 1
    sfr_w(8'hB1, 8'h02); peek("R2 echo set", 8'hB1, 8'h03);
    sfr_w(8'hB1, 8'h00); peek("R2 bit0 kept", 8'hB1, 8'h01);
    rd(16'hFF20, 8'h44); chk("R4 echo ignored when off", got, 8'h44);

    // R3: unlock then enable
    sfr_w(8'hB2, 8'hA5); sfr_w(8'hB1, 8'h00);
    peek("R3 enabled", 8'hB1, 8'h00);
    peek("R10 other addr", 8'h80, 8'h00);

    // R5: quiet local accesses
    wr(16'hFF10, 8'h11); chk("R5 no wr strobe", str_wr, 1);
    wr(16'hFF20, 8'h22);
    wr(16'hFFFF, 8'hF0);
    rd(16'hFF10, 8'hEE); chk("R5 local read", got, 8'h11);
    chk("R5 no rd strobe", str_rd, 1);
    rd(16'hFFFF, 8'hEE); chk("R5 top of window", got, 8'hF0);
    rd(16'hFEFF, 8'h61); chk("R7 below window", got, 8'h61);
    chk("R7 strobe below window", str_rd, 0);

    // R6: echo on
    sfr_w(8'hB1, 8'h02); peek("R2 echo on bit0 kept", 8'hB1, 8'h02);
    wr(16'hFF30, 8'h33); chk("R6 echo wr strobe", str_wr, 0);
    rd(16'hFF30, 8'hEE); chk("R6 data from RAM", got, 8'h33);
    chk("R6 echo rd strobe", str_rd, 0);
    wr(16'h0040, 8'h90); chk("R7 outside write", str_wr, 0);

    // R3: cancellation cases
    sfr_w(8'hB2, 8'hA5); sfr_w(8'hC0, 8'h00); sfr_w(8'hB1, 8'h03);
    peek("R3 cancelled by other write", 8'hB1, 8'h02);
    sfr_w(8'hB2, 8'h5A); sfr_w(8'hB1, 8'h03);
    peek("R3 wrong key", 8'hB1, 8'h02);

    // R8: RAM untouched while off
    sfr_w(8'hB2, 8'hA5); sfr_w(8'hB1, 8'h01);
    peek("R3 disabled again", 8'hB1, 8'h01);
    wr(16'hFF10, 8'h99);
    sfr_w(8'hB2, 8'hA5); sfr_w(8'hB1, 8'h00);
    rd(16'hFF10, 8'hEE); chk("R8 RAM kept", got, 8'h11);

    // R11: access with a same-cycle control write uses old value
    step(1, 8'hB1, 8'h02, 1, 0, 16'hFF20, 8'h00, 8'hEE);
    chk("R11 old echo=0 no strobe", str_rd, 1);
    chk("R11 read data", got, 8'h22);
    sfr_w(8'hB2, 8'hA5);
    step(1, 8'hB1, 8'h03, 1, 1, 16'hFF40, 8'h4D, 8'h00);
    chk("R11 confirm write same cycle", str_wr, 0);
    peek("R11 now off", 8'hB1, 8'h03);
    sfr_w(8'hB2, 8'hA5); sfr_w(8'hB1, 8'h00);
    rd(16'hFF40, 8'hEE); chk("R11 write landed on chip", got, 8'h4D);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule